// File: doc/BRIEF.md
# Serial SAR Converter Control Sequencer

This block is the digital half of a four-channel, 12-bit successive-approximation converter. A host talks to it over a four-wire serial link: active-low select, serial clock, data in and data out. Every step of a conversion is paced by the host's serial clock. The block has no conversion clock of its own. A system clock only oversamples the serial pins. The block does not sample any analog quantity itself. It drives the analog parts through digital controls: the positive-input channel selects, the negative-input selects, the track/hold switch, the trial code for the capacitive DAC and a power-level code. It reads a single comparator bit.

A transaction starts when the host lowers select and clocks in an 8-bit control word. The word opens with a start bit and carries the channel, the input mode, the output coding and a power code. The last three serial clocks of the word are the acquisition window. At the falling edge after the final word bit, the hold switch opens and the hold node moves to the negative input. From then on, each rising serial edge fixes one result bit from the comparator, and each falling edge presents that bit on data out, MSB first. A strobe marks the end of acquisition for a DSP serial port. When a conversion completes, the requested power code takes effect for the next time the block is deselected. Selecting the block again raises it to full power.

Top module: `sarseq_top`

## Requirements
- R1: The control word is 8 bits, taken MSB first on rising serial edges while select is low. Rising edges with data in low are ignored until the first 1, which is the start bit in word bit 7. Bits 6:5 give the channel. Bit 4 set means bipolar. Bit 3 set means single-ended. Bit 2 has no effect. Bits 1:0 give the power code. Once a conversion has completed, a new start bit accepted while select is still low begins the next word.
- R2: `track` rises at the falling serial edge after the 5th word bit. It falls at the falling edge after the 8th bit, so it is high for three serial periods.
- R3: In single-ended mode, `pos_sel` is one-hot on the word's channel while `track` is high. `neg_com` is high from the end of acquisition until the LSB has been presented.
- R4: In pseudo-differential mode with channel c, `pos_sel` is one-hot on c during tracking. During the conversion, `neg_sel` is one-hot on c XOR 1, which pairs channel 0 with 1 and channel 2 with 3.
- R5: At the end of acquisition, `dac_code` is 0x800. Each rising edge of the conversion keeps the current trial bit if `cmp_in` is 1 and clears it if `cmp_in` is 0. The next lower bit is set at the following falling edge. After the last decision, `dac_code` is the converted code.
- R6: Result bit i (with i = 0 for the MSB) is presented on `dout` at the falling edge after word-bit rise 9+i. While the block is selected, `dout` changes only at falling edges. `dout` returns to 0 at the falling edge after the LSB was presented.
- R7: In bipolar mode, the MSB on `dout` is inverted, which turns the result into two's complement. `dac_code` itself stays in offset binary.
- R8: `sstrb` rises at the end of acquisition and falls at the falling edge that presents the MSB.
- R9: `dout_oe` is high exactly when select was low at the previous system clock.
- R10: Select going high aborts any transaction. `track`, the negative-input selects and `sstrb` clear, `dout` returns to 0, and the block waits for a new start bit.
- R11: `pwr_ctl` uses 11 for normal, 10 for reduced, 01 for fast power-down and 00 for full power-down. It reads 11 while the block is selected. After a completed conversion, it reads that word's power code while the block is deselected. `shdn_n` low forces 00 and aborts like R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial control data, sampled on rising edges |
| shdn_n | input | 1 | Active-low hardwired shutdown |
| cmp_in | input | 1 | Comparator result, 1 when input is at or above the trial code |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for the data-out pad |
| sstrb | output | 1 | Conversion strobe |
| track | output | 1 | Track/hold switch closed |
| pos_sel | output | 4 | One-hot positive-input channel select during tracking |
| neg_sel | output | 4 | One-hot negative-input channel select during conversion |
| neg_com | output | 1 | Hold node on the common pin during conversion |
| dac_code | output | 12 | SAR trial code for the capacitive DAC |
| pwr_ctl | output | 2 | Power-level code for the analog section |

## Verification
The assertions assume that every serial input is already synchronous to `clk` and holds for at least one system clock between changes. They also assume that select and `shdn_n` never toggle on the same system clock as a serial edge. The bench holds `sclk` at each level for three system clocks and drives all inputs at the falling system edge. It leaves several idle clocks around each select and shutdown change. The comparator is modelled as `dac_code` compared against a fixed integer input value, so `cmp_in` is always a function of the current trial code.

// File: rtl/sarseq_pkg.sv
package sarseq_pkg;

   typedef enum logic [1:0] {
      PH_WAIT = 2'd0,
      PH_CMD  = 2'd1,
      PH_CONV = 2'd2,
      PH_DONE = 2'd3
   } phase_t;

   localparam logic [1:0] PWR_FULL_OFF = 2'b00;
   localparam logic [1:0] PWR_FAST_OFF = 2'b01;
   localparam logic [1:0] PWR_REDUCED  = 2'b10;
   localparam logic [1:0] PWR_NORMAL   = 2'b11;

endpackage

// File: rtl/sarseq_edges.sv
// Oversamples the serial pins and turns them into one-cycle edge events.
module sarseq_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk,
   input  logic cs_n,
   input  logic shdn_n,
   output logic rise,
   output logic fall,
   output logic abort,
   output logic sel_q,
   output logic awake_q
);
   logic sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q  <= 1'b0;
         sel_q   <= 1'b0;
         awake_q <= 1'b1;
      end else begin
         sclk_q  <= sclk;
         sel_q   <= !cs_n;
         awake_q <= shdn_n;
      end
   end

   assign abort = cs_n || !shdn_n;
   assign rise  = sclk && !sclk_q && !abort;
   assign fall  = !sclk && sclk_q && !abort;
endmodule

// File: rtl/sarseq_cmd.sv
// Shift register for the control word, with a start-bit detector and a bit counter.
module sarseq_cmd #(
   parameter int CW_BITS = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               clr,
   input  logic                               rise,
   input  logic                               din,
   input  logic                               start_ok,
   input  logic                               shift_ok,
   output logic [CW_BITS-1:0]                 word,
   output logic [$clog2(CW_BITS+1)-1:0]       nbits
);
   localparam int CNT_W = $clog2(CW_BITS + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(CW_BITS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word  <= '0;
         nbits <= '0;
      end else if (clr) begin
         nbits <= '0;
      end else if (rise) begin
         if (start_ok) begin
            if (din) begin
               word  <= CW_BITS'(1);
               nbits <= CNT_W'(1);
            end
         end else if (shift_ok && nbits < FULL) begin
            word  <= {word[CW_BITS-2:0], din};
            nbits <= nbits + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/sarseq_sar.sv
// Successive-approximation register; it also serves as the serial result source.
module sarseq_sar #(
   parameter int RES_BITS     = 12,
   parameter bit TWOS_BIPOLAR = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                begin_conv,
   input  logic                decide,
   input  logic                emit,
   input  logic                quiet,
   input  logic                cmp_in,
   input  logic                bipolar,
   output logic [RES_BITS-1:0] dac_code,
   output logic                dout,
   output logic                last
);
   localparam int IDX_W = $clog2(RES_BITS);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_BITS - 1);
   localparam logic [RES_BITS-1:0] MID = {1'b1, {(RES_BITS-1){1'b0}}};

   logic [IDX_W-1:0] idx;
   logic             cur_bit;
   logic             coded;

   assign cur_bit = dac_code[idx];
   assign last    = (idx == '0);

   generate
      if (TWOS_BIPOLAR) begin : g_twos
         assign coded = cur_bit ^ (bipolar && (idx == TOP_IDX));
      end else begin : g_offset
         logic unused_bip;
         assign unused_bip = bipolar;
         assign coded      = cur_bit;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_code <= '0;
         idx      <= '0;
         dout     <= 1'b0;
      end else if (clr) begin
         dac_code <= '0;
         idx      <= '0;
         dout     <= 1'b0;
      end else if (begin_conv) begin
         dac_code <= MID;
         idx      <= TOP_IDX;
      end else if (decide) begin
         dac_code[idx] <= cmp_in;
      end else if (emit) begin
         dout <= coded;
         if (idx != '0) begin
            dac_code[idx - IDX_W'(1)] <= 1'b1;
            idx <= idx - IDX_W'(1);
         end
      end else if (quiet) begin
         dout <= 1'b0;
      end
   end
endmodule

// File: rtl/sarseq_mux.sv
// Decodes the latched input configuration into analog multiplexer selects.
module sarseq_mux #(
   parameter int CH_BITS = 2
) (
   input  logic                      track,
   input  logic                      hold,
   input  logic [CH_BITS-1:0]        cfg_ch,
   input  logic                      cfg_sgl,
   output logic [(1<<CH_BITS)-1:0]   pos_sel,
   output logic [(1<<CH_BITS)-1:0]   neg_sel,
   output logic                      neg_com
);
   localparam int NCH = 1 << CH_BITS;

   logic [CH_BITS-1:0] partner;
   assign partner = cfg_ch ^ CH_BITS'(1);

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         assign pos_sel[c] = track && (cfg_ch == CH_BITS'(c));
         assign neg_sel[c] = hold && !cfg_sgl && (partner == CH_BITS'(c));
      end
   endgenerate

   assign neg_com = hold && cfg_sgl;
endmodule

// File: rtl/sarseq_top.sv
module sarseq_top #(
   parameter int RES_BITS     = 12,
   parameter int CH_BITS      = 2,
   parameter int CW_BITS      = 8,
   parameter int ACQ_CYCLES   = 3,
   parameter bit TWOS_BIPOLAR = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cs_n,
   input  logic                     sclk,
   input  logic                     din,
   input  logic                     shdn_n,
   input  logic                     cmp_in,
   output logic                     dout,
   output logic                     dout_oe,
   output logic                     sstrb,
   output logic                     track,
   output logic [(1<<CH_BITS)-1:0]  pos_sel,
   output logic [(1<<CH_BITS)-1:0]  neg_sel,
   output logic                     neg_com,
   output logic [RES_BITS-1:0]      dac_code,
   output logic [1:0]               pwr_ctl
);
   import sarseq_pkg::*;

   localparam int CNT_W    = $clog2(CW_BITS + 1);
   localparam int CH_LO    = CW_BITS - 1 - CH_BITS;
   localparam int BIP_POS  = CH_LO - 1;
   localparam int SGL_POS  = CH_LO - 2;
   localparam int TRACK_AT = CW_BITS - ACQ_CYCLES;
   localparam int P_CH     = CH_LO - ACQ_CYCLES;
   localparam int P_BIP    = BIP_POS - ACQ_CYCLES;
   localparam int P_SGL    = SGL_POS - ACQ_CYCLES;

   generate
      if (RES_BITS < 2) begin : g_bad_res
         $error("sarseq_top: RES_BITS must be at least 2");
      end
      if (CH_BITS < 1) begin : g_bad_ch
         $error("sarseq_top: CH_BITS must be at least 1");
      end
      if (CW_BITS < CH_BITS + 5) begin : g_bad_cw
         $error("sarseq_top: CW_BITS too small for the word layout");
      end
      if (ACQ_CYCLES < 1 || ACQ_CYCLES > SGL_POS) begin : g_bad_acq
         $error("sarseq_top: ACQ_CYCLES must leave the mode bits received");
      end
   endgenerate

   logic rise, fall, abort, sel_q, awake_q;
   logic [CW_BITS-1:0] word;
   logic [CNT_W-1:0]   nbits;
   phase_t             phase;
   logic               hold, decided, last;
   logic [CH_BITS-1:0] cfg_ch;
   logic               cfg_bip, cfg_sgl;
   logic [1:0]         mode_q;
   logic               start_ok, shift_ok;
   logic               acq_begin, acq_end, emit;

   sarseq_edges u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk    (sclk),
      .cs_n    (cs_n),
      .shdn_n  (shdn_n),
      .rise    (rise),
      .fall    (fall),
      .abort   (abort),
      .sel_q   (sel_q),
      .awake_q (awake_q)
   );

   assign start_ok = (phase == PH_WAIT) || (phase == PH_DONE);
   assign shift_ok = (phase == PH_CMD);

   sarseq_cmd #(.CW_BITS(CW_BITS)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (abort),
      .rise     (rise),
      .din      (din),
      .start_ok (start_ok),
      .shift_ok (shift_ok),
      .word     (word),
      .nbits    (nbits)
   );

   assign acq_begin = (phase == PH_CMD) && fall && !track && (nbits == CNT_W'(TRACK_AT));
   assign acq_end   = (phase == PH_CMD) && fall && (nbits == CNT_W'(CW_BITS));
   assign emit      = (phase == PH_CONV) && fall && decided;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_WAIT;
         track   <= 1'b0;
         hold    <= 1'b0;
         sstrb   <= 1'b0;
         decided <= 1'b0;
         cfg_ch  <= '0;
         cfg_bip <= 1'b0;
         cfg_sgl <= 1'b0;
         mode_q  <= PWR_NORMAL;
      end else if (abort) begin
         phase   <= PH_WAIT;
         track   <= 1'b0;
         hold    <= 1'b0;
         sstrb   <= 1'b0;
         decided <= 1'b0;
      end else begin
         unique case (phase)
            PH_WAIT, PH_DONE: begin
               if (rise && din) phase <= PH_CMD;
            end
            PH_CMD: begin
               if (acq_begin) begin
                  track   <= 1'b1;
                  cfg_ch  <= word[P_CH +: CH_BITS];
                  cfg_bip <= word[P_BIP];
                  cfg_sgl <= word[P_SGL];
               end else if (acq_end) begin
                  track   <= 1'b0;
                  hold    <= 1'b1;
                  sstrb   <= 1'b1;
                  decided <= 1'b0;
                  phase   <= PH_CONV;
               end
            end
            PH_CONV: begin
               if (rise) begin
                  decided <= 1'b1;
               end else if (emit) begin
                  decided <= 1'b0;
                  sstrb   <= 1'b0;
                  if (last) begin
                     phase  <= PH_DONE;
                     hold   <= 1'b0;
                     mode_q <= word[1:0];
                  end
               end
            end
            default: phase <= PH_WAIT;
         endcase
      end
   end

   sarseq_sar #(.RES_BITS(RES_BITS), .TWOS_BIPOLAR(TWOS_BIPOLAR)) u_sar (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (abort),
      .begin_conv (acq_end),
      .decide     ((phase == PH_CONV) && rise),
      .emit       (emit),
      .quiet      ((phase == PH_DONE) && fall),
      .cmp_in     (cmp_in),
      .bipolar    (cfg_bip),
      .dac_code   (dac_code),
      .dout       (dout),
      .last       (last)
   );

   sarseq_mux #(.CH_BITS(CH_BITS)) u_mux (
      .track   (track),
      .hold    (hold),
      .cfg_ch  (cfg_ch),
      .cfg_sgl (cfg_sgl),
      .pos_sel (pos_sel),
      .neg_sel (neg_sel),
      .neg_com (neg_com)
   );

   assign dout_oe = sel_q;
   assign pwr_ctl = !awake_q ? PWR_FULL_OFF : (sel_q ? PWR_NORMAL : mode_q);

endmodule

// File: rtl/sarseq_checker.sv
module sarseq_checker #(
   parameter int RES_BITS = 12,
   parameter int CH_BITS  = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cs_n,
   input logic                    sclk,
   input logic                    shdn_n,
   input logic                    dout,
   input logic                    dout_oe,
   input logic                    sstrb,
   input logic                    track,
   input logic [(1<<CH_BITS)-1:0] neg_sel,
   input logic                    neg_com,
   input logic [RES_BITS-1:0]     dac_code,
   input logic [1:0]              pwr_ctl
);
   localparam logic [RES_BITS-1:0] MID = {1'b1, {(RES_BITS-1){1'b0}}};

   assert_oe_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |=> dout_oe);
   assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> !dout_oe);

   assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (!sstrb && !track && neg_sel == '0 && !neg_com));

   assert_shutdown_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_n |=> (pwr_ctl == 2'b00));

   assert_midscale_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sstrb) |-> (dac_code == MID));

   assert_one_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({track, |neg_sel, neg_com}));

   assert_dout_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((dout != $past(dout)) && !$past(cs_n) && $past(shdn_n))
         |-> (!$past(sclk) && $past(sclk, 2)));

endmodule

bind sarseq_top sarseq_checker #(.RES_BITS(RES_BITS), .CH_BITS(CH_BITS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .sclk     (sclk),
   .shdn_n   (shdn_n),
   .dout     (dout),
   .dout_oe  (dout_oe),
   .sstrb    (sstrb),
   .track    (track),
   .neg_sel  (neg_sel),
   .neg_com  (neg_com),
   .dac_code (dac_code),
   .pwr_ctl  (pwr_ctl)
);

// File: tb/tb_sarseq_top.sv
`timescale 1ns/1ps
module tb_sarseq_top;
   localparam int HP = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, shdn_n = 1'b1;
   logic cmp_in;
   logic dout, dout_oe, sstrb, track, neg_com;
   logic [3:0] pos_sel, neg_sel;
   logic [11:0] dac_code;
   logic [1:0] pwr_ctl;
   int vin = 0;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   assign cmp_in = (vin >= int'(dac_code));

   sarseq_top dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .shdn_n(shdn_n), .cmp_in(cmp_in), .dout(dout), .dout_oe(dout_oe),
      .sstrb(sstrb), .track(track), .pos_sel(pos_sel), .neg_sel(neg_sel),
      .neg_com(neg_com), .dac_code(dac_code), .pwr_ctl(pwr_ctl)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference model, advanced once per system clock.
   int m_ph = 0, m_nb = 0, m_word = 0, m_trk = 0, m_hold = 0, m_stb = 0;
   int m_dec = 0, m_dac = 0, m_idx = 0, m_dout = 0, m_mode = 3;
   int m_ch = 0, m_bip = 0, m_sgl = 0;
   int p_sclk = 0, p_sel = 0, p_awake = 1;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_nb = 0; m_word = 0; m_trk = 0; m_hold = 0; m_stb = 0;
         m_dec = 0; m_dac = 0; m_idx = 0; m_dout = 0; m_mode = 3;
         m_ch = 0; m_bip = 0; m_sgl = 0;
         p_sclk = 0; p_sel = 0; p_awake = 1;
      end else begin
         int r, f;
         bit ab;
         ab = cs_n || !shdn_n;
         r = (sclk && p_sclk == 0 && !ab) ? 1 : 0;
         f = (!sclk && p_sclk == 1 && !ab) ? 1 : 0;
         if (ab) begin
            m_ph = 0; m_nb = 0; m_trk = 0; m_hold = 0; m_stb = 0; m_dec = 0;
            m_dac = 0; m_idx = 0; m_dout = 0;
         end else if (m_ph == 0 || m_ph == 3) begin
            if (r == 1 && din) begin
               m_ph = 1; m_word = 1; m_nb = 1;
            end else if (m_ph == 3 && f == 1) m_dout = 0;
         end else if (m_ph == 1) begin
            if (r == 1 && m_nb < 8) begin
               m_word = ((m_word << 1) | int'(din)) & 255; m_nb++;
            end
            if (f == 1 && m_nb == 5 && m_trk == 0) begin
               m_trk = 1; m_ch = (m_word >> 2) & 3; m_bip = (m_word >> 1) & 1; m_sgl = m_word & 1;
            end else if (f == 1 && m_nb == 8) begin
               m_trk = 0; m_hold = 1; m_stb = 1; m_dec = 0; m_ph = 2; m_dac = 2048; m_idx = 11;
            end
         end else begin
            if (r == 1) begin
               m_dec = 1;
               if (vin >= m_dac) m_dac = m_dac | (1 << m_idx);
               else m_dac = m_dac & ~(1 << m_idx);
            end else if (f == 1 && m_dec == 1) begin
               m_dec = 0; m_stb = 0;
               m_dout = ((m_dac >> m_idx) & 1) ^ ((m_bip == 1 && m_idx == 11) ? 1 : 0);
               if (m_idx > 0) begin
                  m_dac = m_dac | (1 << (m_idx - 1)); m_idx--;
               end else begin
                  m_ph = 3; m_hold = 0; m_mode = m_word & 3;
               end
            end
         end
         p_sclk = int'(sclk); p_sel = cs_n ? 0 : 1; p_awake = int'(shdn_n);
      end
   end

   // Per-clock comparison of every output against the model.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         int e_pos, e_neg, e_com;
         e_pos = (m_trk == 1) ? (1 << m_ch) : 0;
         e_neg = (m_hold == 1 && m_sgl == 0) ? (1 << (m_ch ^ 1)) : 0;
         e_com = (m_hold == 1 && m_sgl == 1) ? 1 : 0;
         chk("R9 dout_oe", int'(dout_oe), p_sel);
         chk("R11 pwr_ctl", int'(pwr_ctl), (p_awake == 0) ? 0 : ((p_sel == 1) ? 3 : m_mode));
         chk("R2 track", int'(track), m_trk);
         chk((m_sgl == 1) ? "R3 pos_sel" : "R4 pos_sel", int'(pos_sel), e_pos);
         chk("R4 neg_sel", int'(neg_sel), e_neg);
         chk("R3 neg_com", int'(neg_com), e_com);
         chk("R5 dac_code", int'(dac_code), m_dac);
         chk("R6 dout", int'(dout), m_dout);
         chk("R8 sstrb", int'(sstrb), m_stb);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic d, output logic o);
      din = d;
      tick(HP);
      o = dout;
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
   endtask

   task automatic send_word(input logic [7:0] w, input int lead);
      logic o;
      for (int i = 0; i < lead; i++) sbit(1'b0, o);
      for (int i = 7; i >= 0; i--) sbit(w[i], o);
   endtask

   // One full conversion; the result is read back from dout.
   task automatic convert(input logic [7:0] w, input int v, input int lead, output int res);
      logic o;
      vin = v;
      if (cs_n) begin
         cs_n = 1'b0;
         tick(3);
      end
      send_word(w, lead);
      res = 0;
      for (int k = 9; k <= 21; k++) begin
         sbit(1'b0, o);
         if (k >= 10) res = (res << 1) | int'(o);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int res;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      chk("R9 reset oe", int'(dout_oe), 0);
      chk("R11 reset pwr", int'(pwr_ctl), 3);
      chk("R5 reset dac", int'(dac_code), 0);

      // R1 R3 R5 R6: single-ended ch2, unipolar, two ignored leading zeros
      convert(8'hCB, 'hA5C, 2, res);
      chk("R6 result ch2 unipolar", res, 'hA5C);
      cs_n = 1'b1; tick(4);

      // R4 R7: pseudo-differential ch1, bipolar, fast power-down afterwards
      convert(8'hB1, 'h123, 0, res);
      chk("R7 bipolar result", res, 'h923);
      cs_n = 1'b1; tick(4);
      chk("R11 fast power-down", int'(pwr_ctl), 1);

      // R4: pseudo-differential ch2, full-scale input, full power-down
      convert(8'hC0, 'hFFF, 1, res);
      chk("R5 full scale", res, 'hFFF);
      cs_n = 1'b1; tick(4);
      chk("R11 full power-down", int'(pwr_ctl), 0);
      cs_n = 1'b0; tick(3);
      chk("R11 wake on select", int'(pwr_ctl), 3);

      // R1: next word while still selected; reserved bit set has no effect
      convert(8'h9F, 0, 3, res);
      chk("R1 reserved bit ignored", res, 'h800);
      cs_n = 1'b1; tick(4);
      chk("R1 power code applied", int'(pwr_ctl), 3);

      // R10: abort in mid conversion, then a clean conversion
      cs_n = 1'b0; tick(3);
      vin = 'h400;
      send_word(8'hCB, 0);
      begin
         logic o;
         sbit(1'b0, o); sbit(1'b0, o);
      end
      cs_n = 1'b1; tick(3);
      chk("R10 abort sstrb", int'(sstrb), 0);
      chk("R10 abort neg_com", int'(neg_com), 0);
      chk("R10 abort dout", int'(dout), 0);
      convert(8'hEB, 'h7FF, 0, res);
      chk("R10 recovery result", res, 'h7FF);

      // R1: back-to-back conversion without deselecting
      convert(8'hA3, 'h0F0, 0, res);
      chk("R1 back-to-back", res, 'h0F0);
      cs_n = 1'b1; tick(4);

      // R11: shutdown during a conversion
      cs_n = 1'b0; tick(3);
      send_word(8'hCB, 0);
      begin
         logic o;
         sbit(1'b0, o);
      end
      shdn_n = 1'b0; tick(3);
      chk("R11 shutdown pwr", int'(pwr_ctl), 0);
      chk("R11 shutdown aborts", int'(neg_com), 0);
      shdn_n = 1'b1; cs_n = 1'b1; tick(4);
      chk("R11 mode kept after shutdown", int'(pwr_ctl), 3);

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule